// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Commit

This block sits between a serial memory's bus protocol engine and its storage array. Once the engine has decoded a write command and its word address, it passes each received data byte to the block. The block keeps the bytes in a page-sized staging buffer and records which entries were loaded. When the host ends the command with STOP, the block copies the loaded bytes into the array during one self-timed write cycle. Bytes that nobody sent leave the array untouched.

For the whole write cycle the block raises `busy`. The protocol engine uses that flag to stop acknowledging, which lets a host poll until the cycle is over. A write-protect input is sampled when STOP arrives. If it is high, the buffered bytes are thrown away and no cycle starts. The length of the cycle is a parameter counted in system clocks.

Top module: `pgwr_commit`

## Requirements
- R1: After synchronous reset, `busy` and `mem_we` are low.
- R2: `addr_load` latches the page base (upper address bits) and the starting offset (low log2(PAGE_BYTES) bits, 5 bits by default). Each accepted data byte goes to the current offset, and then only the offset increments. Every committed byte carries the latched page base.
- R3: Incrementing past offset PAGE_BYTES-1 wraps to offset 0 of the same page. A later byte sent to an offset that was already loaded replaces the earlier byte.
- R4: During a commit, only loaded offsets are written. One write is issued per clock, in ascending offset order, in busy cycles 1 to PAGE_BYTES. `mem_we` is never high while `busy` is low.
- R5: A commit starts only on STOP with at least one byte loaded. A STOP with no data starts nothing. A repeated START (`restart_seen`) discards the buffered bytes.
- R6: `busy` rises in the cycle after the STOP strobe and stays high for exactly CYCLE_CLKS cycles.
- R7: While `busy` is high, `addr_load`, `byte_vld`, `stop_seen` and `restart_seen` have no effect. This includes a load that arrives in the last busy cycle.
- R8: With `wp_in` high when STOP arrives, no write is issued, `busy` stays low and the buffered bytes are discarded.
- R9: A `byte_vld` strobe in the same cycle as `stop_seen` or `restart_seen` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_load | input | 1 | Pulse: a write command's word address is valid |
| addr_in | input | ADDR_W | Starting word address |
| byte_vld | input | 1 | Pulse: a data byte has been received |
| byte_in | input | 8 | Received data byte |
| stop_seen | input | 1 | Pulse: STOP condition detected |
| restart_seen | input | 1 | Pulse: repeated START detected |
| wp_in | input | 1 | Write protect, active high |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Self-timed write cycle in progress |

## Verification
Two events can land in the same clock: the final cycle of a commit and the `addr_load` of a new command. The bench waits exactly CYCLE_CLKS-1 cycles after `busy` is first seen and drives the load in that final busy cycle. It then sends a STOP. The load must have been ignored, so `busy` must stay low and no write must appear. A second overlap is tested by driving a byte strobe together with STOP. The scoreboard must then see only the bytes sent before it.

// File: rtl/pgwr_pkg.sv
// Package pgwr_pkg
// Shared width and data type for the page write buffer.
// Assumes byte-wide array data.
package pgwr_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/pgwr_page_buf.sv
// Module pgwr_page_buf
// Page staging buffer. Holds the page base, the in-page pointer, the data
// bytes and the loaded-byte mask.
// Assumes: PAGE_BYTES is a power of two, so the pointer wraps by itself.
// Assumes: the caller never asserts ld_addr and wr_byte together.
module pgwr_page_buf
    import pgwr_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int PAGE_BYTES = 32,
    parameter int OFS_W      = $clog2(PAGE_BYTES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_addr,
    input  logic [ADDR_W-1:0]   addr_in,
    input  logic                wr_byte,
    input  byte_t               byte_in,
    input  logic                flush,
    input  logic [OFS_W-1:0]    rd_ofs,
    output logic [ADDR_W-OFS_W-1:0] page_base,
    output logic [PAGE_BYTES-1:0]   mask,
    output byte_t               rd_data
);
    localparam int BASE_W = ADDR_W - OFS_W;

    byte_t              store [PAGE_BYTES];
    logic [OFS_W-1:0]   ptr_q;
    logic [BASE_W-1:0]  base_q;
    logic [PAGE_BYTES-1:0] mask_q;
    logic               take_byte;

    // A byte is accepted only when no flush or address load has priority.
    assign take_byte = wr_byte & ~flush & ~ld_addr;

    // Data storage. There is no reset: validity comes from the mask alone.
    always_ff @(posedge clk) begin
        if (take_byte) begin
            store[ptr_q] <= byte_in;
        end
    end

    // Pointer, base and mask. The mask tracks which offsets hold fresh data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            base_q <= '0;
            mask_q <= '0;
        end else if (flush) begin
            mask_q <= '0;
        end else if (ld_addr) begin
            base_q <= addr_in[ADDR_W-1:OFS_W];
            ptr_q  <= addr_in[OFS_W-1:0];
            mask_q <= '0;
        end else if (take_byte) begin
            mask_q[ptr_q] <= 1'b1;
            ptr_q         <= ptr_q + 1'b1;
        end
    end

    assign page_base = base_q;
    assign mask      = mask_q;
    assign rd_data   = store[rd_ofs];
endmodule

// File: rtl/pgwr_cycle_timer.sv
// Module pgwr_cycle_timer
// Self-timed write cycle counter. A start pulse holds busy high for exactly
// CYCLE_CLKS clocks. count gives the position inside the cycle.
// Assumes: start is never pulsed while busy is high.
module pgwr_cycle_timer #(
    parameter int CYCLE_CLKS = 48,
    parameter int CNT_W      = $clog2(CYCLE_CLKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic [CNT_W-1:0] count,
    output logic             done
);
    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    // The final cycle of the write window.
    assign done = busy_q && (cnt_q == CNT_W'(CYCLE_CLKS - 1));

    // Counts through the window and drops busy after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (done) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign busy  = busy_q;
    assign count = cnt_q;
endmodule

// File: rtl/pgwr_commit.sv
// Module pgwr_commit (top)
// Collects the data bytes of a write command into a page buffer. On STOP it
// commits the loaded bytes during a self-timed cycle, scanning one offset per
// clock. Write protect is sampled at STOP.
// Assumes: the protocol engine withholds ACK while busy is high.
// Assumes: CYCLE_CLKS >= PAGE_BYTES, so the scan fits inside the window.
module pgwr_commit
    import pgwr_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int PAGE_BYTES = 32,
    parameter int CYCLE_CLKS = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_vld,
    input  logic [7:0]        byte_in,
    input  logic              stop_seen,
    input  logic              restart_seen,
    input  logic              wp_in,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              busy
);
    localparam int OFS_W  = $clog2(PAGE_BYTES);
    localparam int BASE_W = ADDR_W - OFS_W;
    localparam int CNT_W  = $clog2(CYCLE_CLKS + 1);

    logic                  quiet, term, go, flush, ld, wb;
    logic                  done, scan_on;
    logic [CNT_W-1:0]      count;
    logic [OFS_W-1:0]      scan_ofs;
    logic [BASE_W-1:0]     page_base;
    logic [PAGE_BYTES-1:0] mask;
    byte_t                 rd_data;

    // Bus events are honoured only when no write cycle is running.
    always_comb begin
        quiet = ~busy;
        term  = quiet & (stop_seen | restart_seen);
        go    = quiet & stop_seen & (|mask) & ~wp_in;
        flush = (term & ~go) | done;
        ld    = quiet & addr_load & ~term;
        wb    = quiet & byte_vld & ~term;
    end

    pgwr_page_buf #(
        .ADDR_W    (ADDR_W),
        .PAGE_BYTES(PAGE_BYTES),
        .OFS_W     (OFS_W)
    ) buf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_addr  (ld),
        .addr_in  (addr_in),
        .wr_byte  (wb),
        .byte_in  (byte_in),
        .flush    (flush),
        .rd_ofs   (scan_ofs),
        .page_base(page_base),
        .mask     (mask),
        .rd_data  (rd_data)
    );

    pgwr_cycle_timer #(
        .CYCLE_CLKS(CYCLE_CLKS),
        .CNT_W     (CNT_W)
    ) tmr_i (
        .clk  (clk),
        .rst_n(rst_n),
        .start(go),
        .busy (busy),
        .count(count),
        .done (done)
    );

    // Commit scan: the first PAGE_BYTES busy cycles visit each offset once.
    always_comb begin
        scan_ofs  = count[OFS_W-1:0];
        scan_on   = busy && (count < CNT_W'(PAGE_BYTES));
        mem_we    = scan_on && mask[scan_ofs];
        mem_addr  = {page_base, scan_ofs};
        mem_wdata = rd_data;
    end
endmodule

// File: rtl/pgwr_commit_chk.sv
// Module pgwr_commit_chk
// Port-level protocol checks for pgwr_commit. Attached to it through bind.
module pgwr_commit_chk #(
    parameter int ADDR_W     = 12,
    parameter int PAGE_BYTES = 32,
    parameter int CYCLE_CLKS = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_seen,
    input logic              wp_in,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);
    localparam int OFS_W = $clog2(PAGE_BYTES);

    int run_q;

    // Length of the current busy window, in clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 0;
        else        run_q <= busy ? run_q + 1 : 0;
    end

    p_we_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    p_busy_needs_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_seen));

    p_wp_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(wp_in));

    p_same_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |->
        mem_addr[ADDR_W-1:OFS_W] == $past(mem_addr[ADDR_W-1:OFS_W]));

    p_ascending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |->
        mem_addr[OFS_W-1:0] > $past(mem_addr[OFS_W-1:0]));

    p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_q == CYCLE_CLKS);
endmodule

bind pgwr_commit pgwr_commit_chk #(
    .ADDR_W    (ADDR_W),
    .PAGE_BYTES(PAGE_BYTES),
    .CYCLE_CLKS(CYCLE_CLKS)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_seen(stop_seen),
    .wp_in    (wp_in),
    .busy     (busy),
    .mem_we   (mem_we),
    .mem_addr (mem_addr)
);

// File: tb/pgwr_commit_tb_top.sv
// Scoreboard bench for pgwr_commit. Driver tasks push the expected array
// writes into a queue. A monitor pops and compares them as writes appear.
module pgwr_commit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam int PAGE_BYTES = 32;
    localparam int CYCLE_CLKS = 48;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              addr_load = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic              byte_vld = 1'b0;
    logic [7:0]        byte_in = '0;
    logic              stop_seen = 1'b0;
    logic              restart_seen = 1'b0;
    logic              wp_in = 1'b0;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic              busy;

    int checks = 0;
    int failures = 0;
    logic [ADDR_W+7:0] exp_q[$];

    // Bench-side model of the page buffer.
    logic [7:0]            m_buf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] m_mask = '0;
    logic [ADDR_W-6:0]     m_base = '0;
    logic [4:0]            m_ptr = '0;
    int                    busy_run = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgwr_commit #(
        .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .CYCLE_CLKS(CYCLE_CLKS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .byte_vld(byte_vld), .byte_in(byte_in), .stop_seen(stop_seen),
        .restart_seen(restart_seen), .wp_in(wp_in), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: every array write must match the head of the queue (R4, R5, R8).
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5/R8 unexpected write", int'(mem_addr), 0);
            end else begin
                logic [ADDR_W+7:0] e;
                e = exp_q.pop_front();
                check({mem_addr, mem_wdata} == e, "R4 write addr/data",
                      int'({mem_addr, mem_wdata}), int'(e));
            end
        end
    end

    // Busy window length monitor (R6).
    always @(negedge clk) begin
        if (rst_n && busy) begin
            busy_run++;
        end else begin
            if (busy_run != 0)
                check(busy_run == CYCLE_CLKS, "R6 busy length", busy_run, CYCLE_CLKS);
            busy_run = 0;
        end
    end

    // Each task starts and ends at a falling edge.
    task automatic ld(input logic [ADDR_W-1:0] a, input bit model);
        addr_in = a; addr_load = 1'b1;
        @(negedge clk);
        addr_load = 1'b0;
        if (model) begin
            m_base = a[ADDR_W-1:5]; m_ptr = a[4:0]; m_mask = '0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit model);
        byte_in = b; byte_vld = 1'b1;
        @(negedge clk);
        byte_vld = 1'b0;
        if (model) begin
            m_buf[m_ptr] = b; m_mask[m_ptr] = 1'b1; m_ptr = m_ptr + 1'b1;
        end
    endtask

    // STOP: push the expected writes, then check that busy starts (R6) or stays low.
    task automatic send_stop(input bit model, input string tag);
        bit exp_busy;
        exp_busy = model && (m_mask != 0) && !wp_in;
        if (exp_busy) begin
            for (int o = 0; o < PAGE_BYTES; o++)
                if (m_mask[o]) exp_q.push_back({m_base, 5'(o), m_buf[o]});
        end
        stop_seen = 1'b1;
        @(negedge clk);
        stop_seen = 1'b0;
        byte_vld = 1'b0;
        check(busy == exp_busy, tag, int'(busy), int'(exp_busy));
        if (model) m_mask = '0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        check(1'b0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        check(mem_we == 1'b0, "R1 mem_we after reset", int'(mem_we), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R6: single byte write.
        ld(12'h345, 1'b1);
        send_byte(8'hAA, 1'b1);
        send_stop(1'b1, "R6 busy after single byte");
        wait_idle();

        // R2/R4: partial page, mid-page start.
        ld(12'h7E2, 1'b1);
        send_byte(8'h10, 1'b1);
        send_byte(8'h21, 1'b1);
        send_byte(8'h32, 1'b1);
        send_stop(1'b1, "R4 busy after partial page");
        wait_idle();

        // R3: wrap within the page, later bytes overwrite earlier ones.
        ld(12'h11D, 1'b1);
        for (int i = 0; i < 35; i++) send_byte(8'(8'h40 + i), 1'b1);
        send_stop(1'b1, "R3 busy after wrap");
        wait_idle();

        // R5: STOP with no data starts nothing.
        ld(12'h200, 1'b1);
        send_stop(1'b1, "R5 stop without data");
        repeat (2) @(negedge clk);
        check(busy == 1'b0, "R5 idle after empty stop", int'(busy), 0);

        // R5: repeated START discards buffered bytes.
        ld(12'h260, 1'b1);
        send_byte(8'h77, 1'b1);
        send_byte(8'h78, 1'b1);
        restart_seen = 1'b1; @(negedge clk); restart_seen = 1'b0;
        m_mask = '0;
        send_stop(1'b1, "R5 stop after restart abort");

        // R8: write protect at STOP blocks, then the buffer stays discarded.
        wp_in = 1'b1;
        ld(12'h300, 1'b1);
        send_byte(8'h99, 1'b1);
        send_byte(8'h9A, 1'b1);
        send_stop(1'b1, "R8 busy with wp high");
        wp_in = 1'b0;
        send_stop(1'b1, "R8 buffer discarded after wp");

        // R7: traffic during busy is ignored.
        ld(12'h480, 1'b1);
        send_byte(8'h5C, 1'b1);
        send_stop(1'b1, "R7 busy for ignore test");
        ld(12'h0F0, 1'b0);
        send_byte(8'hEE, 1'b0);
        send_byte(8'hEF, 1'b0);
        stop_seen = 1'b1; @(negedge clk); stop_seen = 1'b0;
        wait_idle();
        send_stop(1'b1, "R7 no commit from busy traffic");

        // R7: a load in the last busy cycle is ignored.
        ld(12'h520, 1'b1);
        send_byte(8'h61, 1'b1);
        send_stop(1'b1, "R7 busy for last-cycle load");
        repeat (CYCLE_CLKS - 1) @(negedge clk);
        check(busy == 1'b1, "R7 still busy on last cycle", int'(busy), 1);
        ld(12'h6A0, 1'b0);
        check(busy == 1'b0, "R6 busy ended", int'(busy), 0);
        send_stop(1'b1, "R7 last-cycle load ignored");

        // R9: a byte strobe together with STOP is dropped.
        ld(12'h040, 1'b1);
        send_byte(8'h11, 1'b1);
        byte_in = 8'h22; byte_vld = 1'b1;
        send_stop(1'b1, "R9 busy with byte on stop");
        wait_idle();

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R4 all expected writes seen", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule